// File: doc/BRIEF.md
# NAND Flash Page-Copy Boot Engine

This block is a boot-time sequencer that moves a span of raw NAND flash into on-chip RAM. After a start pulse it checks whether the chip was strapped to boot from NAND. If not, it reports completion at once. Otherwise it reads the flash one page at a time. Each page gets its own read command and a full address phase, so the copy never streams from the data area into the spare area that follows each page.

The flash interface is driven directly: chip select, command and address latch enables, write and read strobes, a split data bus (output, output enable, input) and the ready/busy line. The bus is 8 or 16 bits wide, set by the `BUS_W` parameter. Every transfer read from the flash is written through a plain RAM write port to word-addressed destination RAM. The destination address then advances by one.

The caller supplies a byte count. The engine keeps a signed remaining-byte counter and stops once that counter goes negative after a page. As a result, a count that is an exact multiple of the page size copies one more page than the count alone suggests.

Top module: `nand_boot_copy`

## Requirements
- R1: With `boot_nand` low, a `start` pulse makes `done` high in the cycle after the edge that sampled `start`. Chip select stays high and no RAM write occurs.
- R2: Each page opens with chip select low and `nand_cmd_lat` high. Exactly one write strobe follows, carrying the read command byte 0x00 on `nand_dq_o[7:0]`. `nand_cmd_lat` then stays high for at least `LATCH_DLY` cycles after that write before it falls. The command latch and the address latch are never high together.
- R3: The address phase holds `nand_adr_lat` high during three write strobes, in this order: 0x00 (column), then `W[15:8]`, then `W[23:16]`. `W` is the working offset: `src_ofs >> 1` when `BUS_W` is 16, `src_ofs` unchanged when it is 8, plus `512*8/BUS_W` for each earlier page. `nand_adr_lat` stays high for at least `LATCH_DLY` cycles after the third write.
- R4: No read strobe begins while `nand_ready` is low after an address phase. The engine waits for it to read high.
- R5: Each page performs `512*8/BUS_W` read transfers. Transfer k of the whole copy is written to RAM address `dest_addr + k`, holding the word read from the flash.
- R6: The number of pages copied is `byte_cnt / 512 + 1`. A count of 0 copies one page, and 512 copies two.
- R7: `nand_dq_oe` is high only while a latch enable is high and the read strobe is high. The write and read strobes are never low together.
- R8: Each read strobe stays low for exactly `RD_STROBE` cycles, and the bus is captured at the end of its last low cycle.
- R9: `done` is high for exactly one cycle per copy. While it is high, chip select is high and both latch enables are low.
- R10: A `start` pulse that arrives while a copy is in progress is ignored. The copy neither restarts nor adds pages or `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a copy |
| boot_nand | input | 1 | High when the boot strap selects NAND |
| dest_addr | input | ADDR_W | First RAM word address |
| src_ofs | input | OFS_W | Source byte offset in the flash |
| byte_cnt | input | CNT_W | Byte count requested |
| nand_cs_n | output | 1 | Flash chip select, active low |
| nand_cmd_lat | output | 1 | Command latch enable |
| nand_adr_lat | output | 1 | Address latch enable |
| nand_wr_n | output | 1 | Write strobe, active low |
| nand_rd_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | BUS_W | Data bus value driven toward the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | BUS_W | Data bus value from the flash |
| nand_ready | input | 1 | Flash ready (high) / busy (low) |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | BUS_W | RAM write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted working offset shows on the row-address bytes of the very next page, and the data words written to RAM are wrong from that page on. A fault in the remaining-byte counter shows only at a page boundary, as a missing or surplus read command and a RAM write count that is off by a full page. A fault in the strobe counter or the capture point shows within the first transfer of a page. Either the low width of the read strobe changes, or an invalid bus value lands in RAM at the first store.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_CMD_DLY,
        S_COL,
        S_ROW_LO,
        S_ROW_HI,
        S_ADR_DLY,
        S_WAIT_RB,
        S_READ,
        S_STORE,
        S_PAGE_END,
        S_FINISH
    } nbc_state_e;

    localparam logic [7:0] NAND_CMD_READ = 8'h00;

    typedef struct packed {
        logic cs_n;
        logic cmd_lat;
        logic adr_lat;
        logic wr_n;
        logic rd_n;
        logic oe;
    } nbc_pins_t;

    function automatic logic is_write_state(nbc_state_e s);
        return (s == S_CMD) || (s == S_COL) || (s == S_ROW_LO) || (s == S_ROW_HI);
    endfunction

    // Moore decode of the flash control pins; wph selects the strobe phase
    function automatic nbc_pins_t pins_for(nbc_state_e s, logic wph);
        nbc_pins_t p;
        p = '{cs_n: 1'b0, cmd_lat: 1'b0, adr_lat: 1'b0, wr_n: 1'b1, rd_n: 1'b1, oe: 1'b0};
        case (s)
            S_IDLE, S_FINISH: p.cs_n = 1'b1;
            S_CMD: begin
                p.cmd_lat = 1'b1;
                p.oe      = 1'b1;
                p.wr_n    = wph;
            end
            S_CMD_DLY: p.cmd_lat = 1'b1;
            S_COL, S_ROW_LO, S_ROW_HI: begin
                p.adr_lat = 1'b1;
                p.oe      = 1'b1;
                p.wr_n    = wph;
            end
            S_ADR_DLY: p.adr_lat = 1'b1;
            S_READ:    p.rd_n = 1'b0;
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/nbc_timer.sv
module nbc_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nbc_pager.sv
module nbc_pager #(
    parameter int BUS_W      = 16,
    parameter int ADDR_W     = 12,
    parameter int OFS_W      = 24,
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              xfer_step,
    input  logic              page_step,
    input  logic [ADDR_W-1:0] dest_in,
    input  logic [OFS_W-1:0]  src_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [ADDR_W-1:0] dest_q,
    output logic [7:0]        row_lo,
    output logic [7:0]        row_hi,
    output logic              last_xfer,
    output logic              more_pages
);
    localparam int XFERS = PAGE_BYTES * 8 / BUS_W;
    localparam int XW    = $clog2(XFERS);
    localparam int RW    = CNT_W + 1;
    localparam logic signed [RW-1:0] PAGE_S = RW'(PAGE_BYTES);

    logic [OFS_W-1:0]     ofs_q;
    logic [OFS_W-1:0]     ofs_init;
    logic signed [RW-1:0] rem_q;
    logic signed [RW-1:0] rem_nxt;
    logic [XW-1:0]        xfer_q;

    // wide devices count the offset in words
    generate
        if (BUS_W == 16) begin : g_wide
            assign ofs_init = src_in >> 1;
        end else begin : g_narrow
            assign ofs_init = src_in;
        end
    endgenerate

    assign rem_nxt    = rem_q - PAGE_S;
    assign more_pages = ~rem_nxt[RW-1];
    assign last_xfer  = (xfer_q == XW'(XFERS - 1));
    assign row_lo     = 8'(ofs_q >> 8);
    assign row_hi     = 8'(ofs_q >> 16);

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q  <= '0;
            rem_q  <= '0;
            dest_q <= '0;
            xfer_q <= '0;
        end else if (init) begin
            ofs_q  <= ofs_init;
            rem_q  <= $signed({1'b0, cnt_in});
            dest_q <= dest_in;
            xfer_q <= '0;
        end else begin
            if (xfer_step) begin
                dest_q <= dest_q + ADDR_W'(1);
                xfer_q <= last_xfer ? '0 : xfer_q + XW'(1);
            end
            if (page_step) begin
                rem_q <= rem_nxt;
                ofs_q <= ofs_q + OFS_W'(XFERS);
            end
        end
    end
endmodule

// File: rtl/nbc_dq_mux.sv
module nbc_dq_mux
    import nbc_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  nbc_state_e       state,
    input  logic [7:0]       row_lo,
    input  logic [7:0]       row_hi,
    output logic [BUS_W-1:0] dq
);
    logic [7:0] b;

    always_comb begin
        case (state)
            S_CMD:    b = NAND_CMD_READ;
            S_ROW_LO: b = row_lo;
            S_ROW_HI: b = row_hi;
            default:  b = 8'h00;
        endcase
    end

    assign dq = BUS_W'(b);
endmodule

// File: rtl/nand_boot_copy.sv
module nand_boot_copy
    import nbc_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int ADDR_W     = 12,
    parameter int OFS_W      = 24,
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 512,
    parameter int LATCH_DLY  = 20,
    parameter int RD_STROBE  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              boot_nand,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [OFS_W-1:0]  src_ofs,
    input  logic [CNT_W-1:0]  byte_cnt,
    output logic              nand_cs_n,
    output logic              nand_cmd_lat,
    output logic              nand_adr_lat,
    output logic              nand_wr_n,
    output logic              nand_rd_n,
    output logic [BUS_W-1:0]  nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [BUS_W-1:0]  nand_dq_i,
    input  logic              nand_ready,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BUS_W-1:0]  ram_wdata,
    output logic              done
);
    localparam int TW  = $clog2(LATCH_DLY + 1);
    localparam int RCW = $clog2(RD_STROBE + 1);
    localparam logic [RCW-1:0] RC_LAST = RCW'(RD_STROBE - 1);

    nbc_state_e       state_q, state_d;
    logic             wph_q;
    logic [RCW-1:0]   rcnt_q;
    logic [BUS_W-1:0] cap_q;
    nbc_pins_t        pins;

    logic       pg_init, xfer_step, page_step, tmr_load, tmr_exp;
    logic       last_xfer, more_pages;
    logic [7:0] row_lo, row_hi;

    assign pg_init   = (state_q == S_IDLE) && start;
    assign xfer_step = (state_q == S_STORE);
    assign page_step = (state_q == S_PAGE_END);
    assign tmr_load  = wph_q && ((state_q == S_CMD) || (state_q == S_ROW_HI));

    nbc_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (TW'(LATCH_DLY)),
        .expired  (tmr_exp)
    );

    nbc_pager #(
        .BUS_W      (BUS_W),
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_pager (
        .clk        (clk),
        .rst        (rst),
        .init       (pg_init),
        .xfer_step  (xfer_step),
        .page_step  (page_step),
        .dest_in    (dest_addr),
        .src_in     (src_ofs),
        .cnt_in     (byte_cnt),
        .dest_q     (ram_addr),
        .row_lo     (row_lo),
        .row_hi     (row_hi),
        .last_xfer  (last_xfer),
        .more_pages (more_pages)
    );

    nbc_dq_mux #(.BUS_W(BUS_W)) u_dq_mux (
        .state  (state_q),
        .row_lo (row_lo),
        .row_hi (row_hi),
        .dq     (nand_dq_o)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:     if (start) state_d = boot_nand ? S_CMD : S_FINISH;
            S_CMD:      if (wph_q) state_d = S_CMD_DLY;
            S_CMD_DLY:  if (tmr_exp) state_d = S_COL;
            S_COL:      if (wph_q) state_d = S_ROW_LO;
            S_ROW_LO:   if (wph_q) state_d = S_ROW_HI;
            S_ROW_HI:   if (wph_q) state_d = S_ADR_DLY;
            S_ADR_DLY:  if (tmr_exp) state_d = S_WAIT_RB;
            S_WAIT_RB:  if (nand_ready) state_d = S_READ;
            S_READ:     if (rcnt_q == RC_LAST) state_d = S_STORE;
            S_STORE:    state_d = last_xfer ? S_PAGE_END : S_READ;
            S_PAGE_END: state_d = more_pages ? S_CMD : S_FINISH;
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            wph_q   <= 1'b0;
            rcnt_q  <= '0;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            wph_q   <= is_write_state(state_q) ? ~wph_q : 1'b0;
            if (state_q == S_READ) begin
                rcnt_q <= (rcnt_q == RC_LAST) ? '0 : rcnt_q + RCW'(1);
                if (rcnt_q == RC_LAST) begin
                    cap_q <= nand_dq_i;
                end
            end else begin
                rcnt_q <= '0;
            end
        end
    end

    assign pins         = pins_for(state_q, wph_q);
    assign nand_cs_n    = pins.cs_n;
    assign nand_cmd_lat = pins.cmd_lat;
    assign nand_adr_lat = pins.adr_lat;
    assign nand_wr_n    = pins.wr_n;
    assign nand_rd_n    = pins.rd_n;
    assign nand_dq_oe   = pins.oe;

    assign ram_we    = (state_q == S_STORE);
    assign ram_wdata = cap_q;
    assign done      = (state_q == S_FINISH);
endmodule

// File: rtl/nbc_chk.sv
module nbc_chk #(
    parameter int ADDR_W    = 12,
    parameter int RD_STROBE = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              cs_n,
    input logic              cmd_lat,
    input logic              adr_lat,
    input logic              wr_n,
    input logic              rd_n,
    input logic              dq_oe,
    input logic              ready,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr
);
    logic [15:0]       low_cnt;
    logic [ADDR_W-1:0] prev_addr;
    logic              have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            prev_addr <= '0;
            have_prev <= 1'b0;
        end else begin
            low_cnt <= rd_n ? 16'd0 : low_cnt + 16'd1;
            if (done) begin
                have_prev <= 1'b0;
            end else if (ram_we) begin
                have_prev <= 1'b1;
                prev_addr <= ram_addr;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_DONE_PINS_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (cs_n && !cmd_lat && !adr_lat)); // R9
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst) !(cmd_lat && adr_lat)); // R2
    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst) dq_oe |-> ((cmd_lat || adr_lat) && rd_n)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!wr_n && !rd_n)); // R7
    AST_READ_READY: assert property (@(posedge clk) disable iff (rst) $fell(rd_n) |-> $past(ready)); // R4
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(rd_n) |-> (low_cnt == 16'(RD_STROBE))); // R8
    AST_RAM_ADDR_STEP: assert property (@(posedge clk) disable iff (rst) (ram_we && have_prev) |-> (ram_addr == prev_addr + ADDR_W'(1))); // R5
endmodule

bind nand_boot_copy nbc_chk #(
    .ADDR_W    (ADDR_W),
    .RD_STROBE (RD_STROBE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .cs_n     (nand_cs_n),
    .cmd_lat  (nand_cmd_lat),
    .adr_lat  (nand_adr_lat),
    .wr_n     (nand_wr_n),
    .rd_n     (nand_rd_n),
    .dq_oe    (nand_dq_oe),
    .ready    (nand_ready),
    .ram_we   (ram_we),
    .ram_addr (ram_addr)
);

// File: tb/nand_boot_copy_tb.sv
module nand_boot_copy_tb;
    localparam int BUS_W     = 16;
    localparam int ADDR_W    = 12;
    localparam int OFS_W     = 24;
    localparam int CNT_W     = 16;
    localparam int LATCH_DLY = 20;
    localparam int RD_STROBE = 3;
    localparam int XFERS     = 512 * 8 / BUS_W;
    localparam int BUSY_CYC  = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              start = 1'b0;
    logic              boot_nand = 1'b1;
    logic [ADDR_W-1:0] dest_addr = '0;
    logic [OFS_W-1:0]  src_ofs = '0;
    logic [CNT_W-1:0]  byte_cnt = '0;
    logic              cs_n, cmd_lat, adr_lat, wr_n, rd_n, dq_oe;
    logic [BUS_W-1:0]  dq_o, dq_i;
    logic              ready = 1'b1;
    logic              ram_we, done;
    logic [ADDR_W-1:0] ram_addr;
    logic [BUS_W-1:0]  ram_wdata;

    nand_boot_copy #(
        .BUS_W(BUS_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .CNT_W(CNT_W),
        .PAGE_BYTES(512), .LATCH_DLY(LATCH_DLY), .RD_STROBE(RD_STROBE)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .boot_nand(boot_nand),
        .dest_addr(dest_addr), .src_ofs(src_ofs), .byte_cnt(byte_cnt),
        .nand_cs_n(cs_n), .nand_cmd_lat(cmd_lat), .nand_adr_lat(adr_lat),
        .nand_wr_n(wr_n), .nand_rd_n(rd_n), .nand_dq_o(dq_o), .nand_dq_oe(dq_oe),
        .nand_dq_i(dq_i), .nand_ready(ready), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;

    // flash model and monitors, all evaluated mid-cycle
    int cyc = 0;
    int cmd_cnt, adr_wr, cmd_bad, adr_bad, cle_bad, ale_bad, rb_bad, oe_bad, re_bad;
    int wr_cnt, wr_bad, done_cnt, cs_seen;
    int cmd_t = 0, adr_t = 0, aidx = 0, busy_left = 0, lowcnt = 0, col = 0;
    logic [7:0] dev_row = '0;
    logic prev_wr = 1'b1, prev_rd = 1'b1, prev_cmd = 1'b0, prev_adr = 1'b0;
    int cur_dest = 0, cur_src = 0;

    function automatic logic [31:0] work_ofs(int pg);
        return 32'((cur_src >> 1) + pg * XFERS);
    endfunction

    assign dq_i = (!cs_n && !rd_n && lowcnt >= RD_STROBE) ? {dev_row, 8'(col)} : 16'hFFFF;

    always @(negedge clk) begin
        logic [31:0] w;
        cyc++;
        if (!cs_n) cs_seen++;
        if (done) done_cnt++;
        if (dq_oe && (!(cmd_lat || adr_lat) || !rd_n)) oe_bad++;
        if (!rd_n && !ready) rb_bad++;
        if (!prev_wr && wr_n) begin
            if (!dq_oe) oe_bad++;
            if (cmd_lat) begin
                cmd_cnt++;
                if (dq_o[7:0] != 8'h00 || adr_lat) cmd_bad++;
                cmd_t = cyc;
                aidx = 0;
                col = 0;
            end else if (adr_lat) begin
                adr_wr++;
                w = work_ofs(cmd_cnt - 1);
                if (aidx == 0 && dq_o != 16'h0000) adr_bad++;
                if (aidx == 1) begin
                    if (dq_o != {8'h00, w[15:8]}) adr_bad++;
                    dev_row = dq_o[7:0];
                end
                if (aidx == 2) begin
                    if (dq_o != {8'h00, w[23:16]}) adr_bad++;
                    busy_left = BUSY_CYC;
                    ready = 1'b0;
                    adr_t = cyc;
                end
                aidx++;
            end
        end
        if (prev_cmd && !cmd_lat && (cyc - cmd_t) < LATCH_DLY) cle_bad++;
        if (prev_adr && !adr_lat && (cyc - adr_t) < LATCH_DLY) ale_bad++;
        if (!rd_n) begin
            lowcnt++;
        end else begin
            if (!prev_rd) begin
                if (lowcnt != RD_STROBE) re_bad++;
                col++;
            end
            lowcnt = 0;
        end
        if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) ready = 1'b1;
        end
        if (ram_we) begin
            w = work_ofs(wr_cnt / XFERS);
            if (ram_addr != ADDR_W'(cur_dest + wr_cnt) ||
                ram_wdata != {w[15:8], 8'(wr_cnt % XFERS)}) begin
                if (wr_bad == 0)
                    $display("FAIL R5 write %0d: addr %0d data %h, expected addr %0d data %h",
                             wr_cnt, ram_addr, ram_wdata, ADDR_W'(cur_dest + wr_cnt),
                             {w[15:8], 8'(wr_cnt % XFERS)});
                wr_bad++;
            end
            wr_cnt++;
        end
        prev_wr = wr_n;
        prev_rd = rd_n;
        prev_cmd = cmd_lat;
        prev_adr = adr_lat;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        cmd_cnt = 0; adr_wr = 0; cmd_bad = 0; adr_bad = 0; cle_bad = 0; ale_bad = 0;
        rb_bad = 0; oe_bad = 0; re_bad = 0; wr_cnt = 0; wr_bad = 0; done_cnt = 0; cs_seen = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && rd_n && wr_n && !cmd_lat && !adr_lat, "R9 reset pins idle",
            {cs_n, rd_n, wr_n, cmd_lat, adr_lat}, 5'b11100);
        chk(!dq_oe && !ram_we && !done, "R7 reset no drive/write/done",
            {dq_oe, ram_we, done}, 0);
    endtask

    task automatic t_no_boot();
        clear_mon();
        boot_nand = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R1 done one cycle after start", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", done, 0);
        repeat (5) @(posedge clk);
        chk(cs_seen == 0 && wr_cnt == 0, "R1 flash untouched", cs_seen + wr_cnt, 0);
        boot_nand = 1'b1;
    endtask

    task automatic t_copy(input int dst, input int src, input int cnt, input logic mid_start,
                          input string name);
        int pages, waited;
        pages = cnt / 512 + 1;
        clear_mon();
        cur_dest = dst;
        cur_src = src;
        @(negedge clk);
        dest_addr = ADDR_W'(dst);
        src_ofs = OFS_W'(src);
        byte_cnt = CNT_W'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dest_addr = '0;
        src_ofs = '0;
        byte_cnt = '0;
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
            // R10: a second request in mid-copy must be ignored
            start = (mid_start && waited == 300);
        end
        start = 1'b0;
        $display("scenario %s: %0d pages, %0d writes", name, cmd_cnt, wr_cnt);
        chk(cs_n && !cmd_lat && !adr_lat, "R9 pins idle at done", {cs_n, cmd_lat, adr_lat}, 3'b100);
        repeat (20) @(posedge clk);
        chk(done_cnt == 1, "R9 R10 one done pulse", done_cnt, 1);
        chk(cmd_cnt == pages, "R6 R10 page count", cmd_cnt, pages);
        chk(wr_cnt == pages * XFERS, "R5 transfers written", wr_cnt, pages * XFERS);
        chk(wr_bad == 0, "R5 R8 RAM address/data", wr_bad, 0);
        chk(cmd_bad == 0 && cle_bad == 0, "R2 command write and hold", cmd_bad + cle_bad, 0);
        chk(adr_bad == 0 && ale_bad == 0, "R3 address bytes and hold", adr_bad + ale_bad, 0);
        chk(adr_wr == 3 * pages, "R3 three address writes per page", adr_wr, 3 * pages);
        chk(rb_bad == 0, "R4 no read while busy", rb_bad, 0);
        chk(oe_bad == 0, "R7 bus drive only on writes", oe_bad, 0);
        chk(re_bad == 0, "R8 read strobe width", re_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_no_boot();
        t_copy(0, 0, 100, 1'b0, "short count one page");
        t_copy(64, 32'h1000, 512, 1'b0, "exact multiple adds a page");
        t_copy(10, 32'h400, 0, 1'b0, "zero count one page");
        t_copy(100, 32'h20400, 1000, 1'b1, "restart ignored, high row byte");
        t_copy(2000, 32'h3FE00, 1024, 1'b0, "row carry across pages");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule